// File: doc/BRIEF.md
# UART FIFO Threshold and Flow-Control Unit

This block holds the transmit and receive word queues of a serial port, each four entries deep, together with the control logic around them. The receive shifter pushes finished words into one queue and the bus side pops them. The bus side pushes words into the other queue and the transmit shifter pops them. The block reports how many words each queue holds. From selectable thresholds it raises a data-request and a DMA-request for each direction. A request on the receive side counts filled slots. A request on the transmit side counts free slots.

The block also drives the ready-to-send output. In hardware mode this output reflects how full the receive side is, and that fullness includes the receive shift register. An early option raises the output while one more word can still be taken. In software mode the output follows a stored bit. Receiver inhibit forces the output to "stop" at once. The ready-to-send and clear-to-send pins each have their own inversion. Flush commands empty the queues and, under the conditions below, ask the shifters to drop their shift registers. Overflow and underflow attempts raise a sticky error flag for that direction.

Top module: `uart_fifo_flow_ctl`

## Requirements
- R1: Each count output gives the number of stored words (0 to 4, 3 bits). Words leave a queue in the order they entered, and `*_rdata` shows the oldest stored word.
- R2: `rx_req` is 1 when `rx_count` is at least N filled slots. N is 1, 2 or 4 for `rx_thresh` codes 0, 1 and 2; code 3 also gives 4.
- R3: `tx_req` is 1 when the number of free transmit slots (4 minus `tx_count`) is at least N. N comes from `tx_thresh` with the same coding as in R2.
- R4: `rx_dma_req` equals `rx_req` AND `rx_dma_en`, and `tx_dma_req` equals `tx_req` AND `tx_dma_en`.
- R5: Let fill be `rx_count` plus `rx_shreg_full`. With `rts_hw_en`=1 and `rts_early`=0, the "stop" level (1 before inversion) is driven only when fill is 5. With `rts_early`=1, it is driven when fill is 4 or more. The level follows count changes in the same cycle they appear.
- R6: With `rts_hw_en`=0, the level equals a stored bit. A pulse on `rts_sw_we` loads `rts_sw_val` into that bit at the next edge. Writes made while `rts_hw_en`=1 are dropped.
- R7: `rx_inhibit`=1 forces the level to "stop" in the same cycle, in either mode.
- R8: `rts_pin` = level XOR `rts_inv`, and `cts_level` = `cts_pin` XOR `cts_inv`. Both are combinational.
- R9: `rx_flush` drives `rx_shreg_clear` high in the same cycle, and `rx_count` is 0 after the edge. A push or pop in that cycle is dropped.
- R10: `tx_flush` leaves `tx_count` at 0 after the edge. `tx_shreg_clear` is 1 only while `tx_flush`, `tx_shreg_full` and not `tx_frame_started` are all true.
- R11: A push into a full queue or a pop from an empty one is ignored, and it sets that direction's `*_fifo_err` at the next edge. The flag stays set until a `*_err_clr` pulse in a cycle with no new error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_thresh | input | 2 | Receive request threshold code |
| tx_thresh | input | 2 | Transmit request threshold code |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_push | input | 1 | Receive shifter delivers a word |
| rx_wdata | input | 9 | Word from receive shifter |
| rx_pop | input | 1 | Bus reads a received word |
| rx_rdata | output | 9 | Oldest received word |
| rx_shreg_full | input | 1 | Receive shift register holds a word |
| rx_flush | input | 1 | Flush receive side |
| rx_err_clr | input | 1 | Clear receive queue error |
| rx_shreg_clear | output | 1 | Request to drop the receive shift register |
| rx_count | output | 3 | Receive queue occupancy |
| rx_req | output | 1 | Receive data request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_fifo_err | output | 1 | Sticky receive queue error |
| tx_push | input | 1 | Bus writes a word to send |
| tx_wdata | input | 9 | Word to send |
| tx_pop | input | 1 | Transmit shifter takes a word |
| tx_rdata | output | 9 | Oldest word to send |
| tx_shreg_full | input | 1 | Transmit shift register loaded |
| tx_frame_started | input | 1 | Transmit frame already on the line |
| tx_flush | input | 1 | Flush transmit side |
| tx_err_clr | input | 1 | Clear transmit queue error |
| tx_shreg_clear | output | 1 | Request to drop the transmit shift register |
| tx_count | output | 3 | Transmit queue occupancy |
| tx_req | output | 1 | Transmit data request |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_fifo_err | output | 1 | Sticky transmit queue error |
| rts_hw_en | input | 1 | Hardware ready-to-send control |
| rts_early | input | 1 | Stop one word early |
| rts_sw_we | input | 1 | Software ready-to-send write strobe |
| rts_sw_val | input | 1 | Software ready-to-send value |
| rx_inhibit | input | 1 | Receiver inhibit |
| rts_inv | input | 1 | Invert ready-to-send pin |
| cts_inv | input | 1 | Invert clear-to-send pin |
| cts_pin | input | 1 | Clear-to-send pin |
| rts_pin | output | 1 | Ready-to-send pin |
| cts_level | output | 1 | Clear-to-send after inversion |

## Verification
Counts, error flags and the stored software bit change at the first clock edge after a push, pop, flush or write strobe. The requests, the ready-to-send pin and `cts_level` then follow combinationally in that same cycle. Inhibit, inversion and the shift-register clear outputs respond combinationally within the cycle their input is applied, with no edge needed. The bench drives every input 1 ns after a rising edge. It checks registered results 1 ns after the next rising edge, and it checks combinational results 1 ns after changing their input, before any edge.

// File: rtl/uffc_pkg.sv
package uffc_pkg;

  // Threshold code to slot count: 0->1, 1->2, 2 and 3 -> 4
  function automatic int unsigned slots_for_code(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Receive side counts filled slots
  function automatic logic fill_demand(input int unsigned filled, input logic [1:0] code);
    return filled >= slots_for_code(code);
  endfunction

  // Transmit side counts free slots
  function automatic logic space_demand(input int unsigned filled, input int unsigned depth,
                                        input logic [1:0] code);
    return (depth - filled) >= slots_for_code(code);
  endfunction

  // Stop level from combined queue plus shift register fill
  function automatic logic flow_stop(input int unsigned filled, input logic shreg,
                                     input logic early, input int unsigned depth);
    int unsigned total;
    total = filled + (shreg ? 1 : 0);
    return early ? (total >= depth) : (total >= depth + 1);
  endfunction

endpackage

// File: rtl/uffc_fifo.sv
module uffc_fifo #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  input  logic              flush,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              err
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;

  // named events for assertions
  logic full, empty, push_ok, pop_ok, overflow, underflow;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign overflow  = push & full & ~flush;
  assign underflow = pop & empty & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
      if (pop_ok)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err_q <= 1'b0;
    else if (overflow | underflow) err_q <= 1'b1;
    else if (err_clr)             err_q <= 1'b0;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;
  assign err   = err_q;

  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !pop) |=> (cnt_q == $past(cnt_q)) && err_q);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/uffc_rts.sv
module uffc_rts #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             shreg_full,
  input  logic             hw_en,
  input  logic             early,
  input  logic             sw_we,
  input  logic             sw_val,
  input  logic             inhibit,
  input  logic             rts_inv,
  output logic             rts_pin
);
  import uffc_pkg::*;

  logic sw_q;
  logic hw_stop, level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sw_q <= 1'b0;
    else if (sw_we && !hw_en)  sw_q <= sw_val;
  end

  assign hw_stop = flow_stop(int'(rx_count), shreg_full, early, DEPTH);
  assign level   = inhibit | (hw_en ? hw_stop : sw_q);
  assign rts_pin = level ^ rts_inv;

  a_r6_sw_locked: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |=> $stable(sw_q));
  a_r5_empty_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !inhibit && rx_count == '0 && !shreg_full) |-> (rts_pin == rts_inv));

endmodule

// File: rtl/uart_fifo_flow_ctl.sv
module uart_fifo_flow_ctl #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rx_thresh,
  input  logic [1:0]        tx_thresh,
  input  logic              rx_dma_en,
  input  logic              tx_dma_en,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              rx_shreg_full,
  input  logic              rx_flush,
  input  logic              rx_err_clr,
  output logic              rx_shreg_clear,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_req,
  output logic              rx_dma_req,
  output logic              rx_fifo_err,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              tx_shreg_full,
  input  logic              tx_frame_started,
  input  logic              tx_flush,
  input  logic              tx_err_clr,
  output logic              tx_shreg_clear,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_req,
  output logic              tx_dma_req,
  output logic              tx_fifo_err,
  input  logic              rts_hw_en,
  input  logic              rts_early,
  input  logic              rts_sw_we,
  input  logic              rts_sw_val,
  input  logic              rx_inhibit,
  input  logic              rts_inv,
  input  logic              cts_inv,
  input  logic              cts_pin,
  output logic              rts_pin,
  output logic              cts_level
);
  import uffc_pkg::*;

  uffc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .flush(rx_flush), .err_clr(rx_err_clr), .rdata(rx_rdata), .count(rx_count),
    .err(rx_fifo_err));

  uffc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .flush(tx_flush), .err_clr(tx_err_clr), .rdata(tx_rdata), .count(tx_count),
    .err(tx_fifo_err));

  uffc_rts #(.DEPTH(DEPTH)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .shreg_full(rx_shreg_full),
    .hw_en(rts_hw_en), .early(rts_early), .sw_we(rts_sw_we), .sw_val(rts_sw_val),
    .inhibit(rx_inhibit), .rts_inv(rts_inv), .rts_pin(rts_pin));

  assign rx_req     = fill_demand(int'(rx_count), rx_thresh);
  assign tx_req     = space_demand(int'(tx_count), DEPTH, tx_thresh);
  assign rx_dma_req = rx_req & rx_dma_en;
  assign tx_dma_req = tx_req & tx_dma_en;

  assign rx_shreg_clear = rx_flush;
  assign tx_shreg_clear = tx_flush & tx_shreg_full & ~tx_frame_started;
  assign cts_level      = cts_pin ^ cts_inv;

  a_r4_rx_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (rx_req && rx_dma_en));
  a_r4_tx_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (tx_req && tx_dma_en));
  a_r7_inhibit_stops: assert property (@(posedge clk) disable iff (!rst_n)
    rx_inhibit |-> (rts_pin != rts_inv));
  a_r10_started_kept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_started |-> !tx_shreg_clear);
  a_r2_empty_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !rx_req);

endmodule

// File: tb/uart_fifo_flow_ctl_test.sv
module uart_fifo_flow_ctl_test;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rx_thresh = '0, tx_thresh = '0;
  logic rx_dma_en = 0, tx_dma_en = 0;
  logic rx_push = 0, rx_pop = 0, rx_shreg_full = 0, rx_flush = 0, rx_err_clr = 0;
  logic tx_push = 0, tx_pop = 0, tx_shreg_full = 0, tx_frame_started = 0, tx_flush = 0, tx_err_clr = 0;
  logic [8:0] rx_wdata = '0, tx_wdata = '0, rx_rdata, tx_rdata;
  logic rts_hw_en = 0, rts_early = 0, rts_sw_we = 0, rts_sw_val = 0, rx_inhibit = 0;
  logic rts_inv = 0, cts_inv = 0, cts_pin = 0;
  logic rx_shreg_clear, tx_shreg_clear, rx_req, tx_req, rx_dma_req, tx_dma_req;
  logic rx_fifo_err, tx_fifo_err, rts_pin, cts_level;
  logic [2:0] rx_count, tx_count;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_fifo_flow_ctl uut (.*);

  // {n[9:7], rx_thresh[6:5], tx_thresh[4:3], dma_en[2], exp_rx_req[1], exp_tx_req[0]}
  localparam logic [9:0] VEC [9] = '{
    {3'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1},
    {3'd1, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0},
    {3'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1},
    {3'd2, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1},
    {3'd3, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0},
    {3'd4, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    {3'd3, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0},
    {3'd0, 2'd1, 2'd2, 1'b1, 1'b0, 1'b1}
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [8:0] dval(input int k);
    return 9'((k * 73 + 5) % 512);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // reset state
    chk("R1 reset rx_count", rx_count, 0);
    chk("R1 reset tx_count", tx_count, 0);
    chk("R3 reset tx_req", tx_req, 1);
    chk("R2 reset rx_req", rx_req, 0);
    chk("R11 reset errors", {rx_fifo_err, tx_fifo_err}, 0);
    chk("R6 reset rts_pin", rts_pin, 0);

    // threshold table walk
    for (int i = 0; i < 9; i++) begin
      logic [9:0] v;
      v = VEC[i];
      rx_flush = 1; tx_flush = 1; cyc(); rx_flush = 0; tx_flush = 0;
      rx_thresh = v[6:5]; tx_thresh = v[4:3];
      rx_dma_en = v[2]; tx_dma_en = v[2];
      for (int k = 0; k < int'(v[9:7]); k++) begin
        rx_push = 1; tx_push = 1; rx_wdata = dval(k); tx_wdata = dval(k + 9);
        cyc();
      end
      rx_push = 0; tx_push = 0; #1;
      chk($sformatf("R1 vec%0d rx_count", i), rx_count, int'(v[9:7]));
      chk($sformatf("R1 vec%0d tx_count", i), tx_count, int'(v[9:7]));
      chk($sformatf("R2 vec%0d rx_req", i), rx_req, v[1]);
      chk($sformatf("R3 vec%0d tx_req", i), tx_req, v[0]);
      chk($sformatf("R4 vec%0d rx_dma_req", i), rx_dma_req, v[1] & v[2]);
      chk($sformatf("R4 vec%0d tx_dma_req", i), tx_dma_req, v[0] & v[2]);
    end
    rx_dma_en = 0; tx_dma_en = 0;

    // R1 order and R11 overflow
    rx_flush = 1; tx_flush = 1; cyc(); rx_flush = 0; tx_flush = 0;
    for (int k = 0; k < 5; k++) begin
      rx_push = 1; rx_wdata = dval(k + 20); cyc();
    end
    rx_push = 0;
    chk("R11 overflow count held", rx_count, 4);
    chk("R11 overflow flag", rx_fifo_err, 1);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R1 order word%0d", k), rx_rdata, dval(k + 20));
      rx_pop = 1; cyc(); rx_pop = 0;
    end
    chk("R1 drained", rx_count, 0);
    rx_err_clr = 1; cyc(); rx_err_clr = 0;
    chk("R11 rx clear", rx_fifo_err, 0);
    tx_pop = 1; cyc(); tx_pop = 0;
    chk("R11 underflow flag", tx_fifo_err, 1);
    chk("R11 underflow count", tx_count, 0);
    chk("R11 rx untouched", rx_fifo_err, 0);
    tx_err_clr = 1; cyc(); tx_err_clr = 0;

    // R5 hardware flow control
    rts_hw_en = 1; rts_early = 0;
    for (int k = 0; k < 4; k++) begin
      rx_push = 1; rx_wdata = dval(k); cyc();
    end
    rx_push = 0;
    chk("R5 full fifo only", rts_pin, 0);
    rx_shreg_full = 1; #1;
    chk("R5 fifo and shreg full", rts_pin, 1);
    rx_shreg_full = 0; rts_early = 1; #1;
    chk("R5 early at 4", rts_pin, 1);
    rx_pop = 1; cyc(); rx_pop = 0;
    chk("R5 early at 3", rts_pin, 0);
    rx_shreg_full = 1; #1;
    chk("R5 early 3 plus shreg", rts_pin, 1);
    rx_shreg_full = 0;

    // R6 software control
    rts_hw_en = 0; rts_sw_we = 1; rts_sw_val = 1; cyc(); rts_sw_we = 0;
    chk("R6 sw write 1", rts_pin, 1);
    rts_hw_en = 1; #1;
    chk("R6 hw takes over", rts_pin, 0);
    rts_sw_we = 1; rts_sw_val = 0; cyc(); rts_sw_we = 0;
    rts_hw_en = 0; #1;
    chk("R6 write ignored under hw", rts_pin, 1);
    rts_sw_we = 1; rts_sw_val = 0; cyc(); rts_sw_we = 0;
    chk("R6 sw write 0", rts_pin, 0);

    // R7 inhibit
    rx_inhibit = 1; #1;
    chk("R7 inhibit stops", rts_pin, 1);
    rx_inhibit = 0; #1;

    // R8 inversion
    rts_inv = 1; #1;
    chk("R8 rts inverted", rts_pin, 1);
    rts_inv = 0; cts_pin = 1; #1;
    chk("R8 cts plain", cts_level, 1);
    cts_inv = 1; #1;
    chk("R8 cts inverted", cts_level, 0);
    cts_inv = 0; cts_pin = 0;

    // R9 receive flush
    rx_flush = 1; rx_push = 1; #1;
    chk("R9 shreg clear", rx_shreg_clear, 1);
    cyc(); rx_flush = 0; rx_push = 0; #1;
    chk("R9 count zero", rx_count, 0);
    chk("R9 clear drops", rx_shreg_clear, 0);

    // R10 transmit flush
    for (int k = 0; k < 2; k++) begin
      tx_push = 1; tx_wdata = dval(k); cyc();
    end
    tx_push = 0;
    tx_shreg_full = 1; tx_frame_started = 0; tx_flush = 1; #1;
    chk("R10 clear unstarted", tx_shreg_clear, 1);
    cyc(); tx_flush = 0;
    chk("R10 count zero", tx_count, 0);
    tx_frame_started = 1; tx_flush = 1; #1;
    chk("R10 keep started", tx_shreg_clear, 0);
    cyc(); tx_flush = 0; tx_shreg_full = 0; tx_frame_started = 0;
    chk("R10 no error on flush", tx_fifo_err, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule